// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block takes a byte stream of received frames and stores it in buffers in system memory. Each buffer is described by a two-word descriptor. The descriptors sit in a ring that starts at a programmable base address. Word 0 of a descriptor holds the buffer's start address, a wrap flag and an ownership flag. Word 1 is written back by the block with the status of that buffer.

A frame may be too long for one buffer. In that case the block closes the current buffer, fetches the next descriptor and carries on, so one frame can fill any number of buffers. When a buffer is closed, the block writes its status word first and then sets the ownership flag in word 0. Software therefore never sees a buffer marked used before its status is in place. If a descriptor is still owned by software, the block reports a resource error and discards the frame. If a frame ends in error or overruns the input holding register, only the buffer being filled is taken back.

The controller is one state machine:

- S_IDLE waits for a captured start byte and then moves to S_FETCH.
- S_FETCH issues the descriptor read. S_FWAIT takes the read data and goes either to S_DATA (buffer free) or to S_DROP (buffer used).
- S_DATA decides what happens next:
  - an overrun or an error byte leads to S_DROP;
  - a full buffer with more data waiting leads to S_STAT;
  - otherwise it goes to S_WR.
- S_WR writes one byte. It returns to S_DATA, or goes on to S_STAT once the end-of-frame byte has been written.
- S_STAT writes word 1. S_MARK writes word 0 and advances the pointer, then returns to S_IDLE after the last buffer or to S_FETCH otherwise.
- S_DROP discards input until the frame's end has passed, then returns to S_IDLE.

Top module: `rx_ring_mgr`

## Requirements
- R1: Descriptor word 0 carries the buffer start address in bits 31:2, the wrap flag in bit 1 and the used flag in bit 0. A frame's bytes are written at consecutive byte addresses, starting from that buffer address.
- R2: The buffer size register is 8 bits wide and counts 64-byte units. A value of 0 acts as 1, so the size range is 64 to 16320 bytes. The reset value is 2 (128 bytes). A buffer never receives more bytes than its size.
- R3: After a buffer is closed, the descriptor pointer moves forward by 8 bytes. If the closed descriptor had its wrap flag set, the pointer returns to the base address instead.
- R4: Closing a buffer takes two writes, in this order:
  - first the status word to pointer+4;
  - then word 0 to the pointer, with the buffer address and wrap flag kept unchanged and bit 0 set to 1.
- R5: Status word layout: bit 14 marks start of frame, bit 15 marks end of frame, and bits 12:0 hold the total frame length. A non-final buffer's status is zero except bit 14, which is set on the first buffer only. Only the final buffer carries bit 15 and the length.
- R6: A fetched descriptor with bit 0 already set is a resource error. The block then:
  - pulses `bna_irq`;
  - sets `bna_flag` until the next successful fetch;
  - increments `res_err_cnt`;
  - writes nothing for that frame and leaves the pointer unchanged, so the next frame re-reads the same descriptor.
- R7: A byte marked with `in_err` aborts the frame. The buffer being filled gets no write-back and the pointer does not move, so the next frame reuses that buffer. Buffers already closed for the aborted frame stay used.
- R8: Overrun handling:
  - A byte that arrives while the previous byte is still held unwritten raises an `ovr_irq` pulse and is lost.
  - The frame is then aborted as in R7.
- R9: The first buffer of a frame starts at its buffer address plus `cfg_offset` (0 to 3 bytes), and its capacity is reduced by the same amount. Later buffers of the frame have no offset.
- R10: A write to the base register sets both the base and the pointer, aligned to 8 bytes, but only while `rx_enable` is low. While `rx_enable` is high such writes are ignored. `cfg_base_rdata` always returns the current pointer.
- R11: A frame begins only on a byte with `in_sof` while `rx_enable` is high. Bytes outside a frame are ignored.
- R12: Memory requests use a valid/ready handshake. A request holds its address and direction stable until it is accepted. A read is answered by `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_enable | input | 1 | Reception enable |
| cfg_base_wr | input | 1 | Base register write strobe |
| cfg_base_wdata | input | 32 | Base register write value |
| cfg_base_rdata | output | 32 | Current descriptor pointer |
| cfg_size_wr | input | 1 | Buffer size register write strobe |
| cfg_size_wdata | input | 8 | Buffer size in 64-byte units |
| cfg_offset | input | 2 | First-buffer start offset in bytes |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte starts a frame |
| in_eof | input | 1 | Byte ends a frame |
| in_err | input | 1 | Frame is in error at this byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| bna_irq | output | 1 | Buffer-not-available pulse |
| bna_flag | output | 1 | Buffer-not-available state |
| res_err_cnt | output | 16 | Resource error count |
| ovr_irq | output | 1 | Overrun pulse |

## Verification
The hardest case to reach from the ports is an overrun. It needs a second input byte to arrive while the first is still waiting for the memory. With fast memory this never happens, because every byte is written long before the next one arrives. The bench therefore holds `mem_req_ready` low while the block is blocked on a descriptor read and sends a whole short frame during that time. It then releases memory and checks two things: the overrun pulses were raised, and the frame left nothing behind, neither a write-back nor a pointer move. A following frame must then land in the same buffer.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    localparam int ADDR_W       = 32;
    localparam int DESC_BYTES   = 8;
    localparam int STAT_LEN_W   = 13;
    localparam int STAT_SOF_BIT = 14;
    localparam int STAT_EOF_BIT = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_FWAIT,
        S_DATA,
        S_WR,
        S_STAT,
        S_MARK,
        S_DROP
    } rx_state_e;

    function automatic logic [31:0] mk_status(input logic fin, input logic first,
                                              input logic [STAT_LEN_W-1:0] len);
        logic [31:0] s;
        s = '0;
        s[STAT_SOF_BIT] = first;
        if (fin) begin
            s[STAT_EOF_BIT] = 1'b1;
            s[STAT_LEN_W-1:0] = len;
        end
        return s;
    endfunction

endpackage

// File: rtl/rx_byte_hold.sv
module rx_byte_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] in_data,
    input  logic          in_eof,
    input  logic          in_err,
    input  logic          consume,
    input  logic          flush,
    output logic          hold_valid,
    output logic [DW-1:0] hold_data,
    output logic          hold_eof,
    output logic          hold_err,
    output logic          ovr
);

    logic busy;

    assign busy = hold_valid && !consume;
    assign ovr  = capture && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            hold_eof   <= 1'b0;
            hold_err   <= 1'b0;
        end else if (flush) begin
            hold_valid <= 1'b0;
        end else if (capture && !busy) begin
            hold_valid <= 1'b1;
            hold_data  <= in_data;
            hold_eof   <= in_eof;
            hold_err   <= in_err;
        end else if (consume) begin
            hold_valid <= 1'b0;
        end
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid && !consume && !flush |=> hold_valid && $stable(hold_data)); // R8

endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr
    import rx_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              adv,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] base
);

    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN = ~(STEP - 1);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (base_wr && !rx_enable) begin
            base_q <= base_wdata & ALIGN;
            ptr_q  <= base_wdata & ALIGN;
        end else if (adv) begin
            ptr_q <= wrap ? base_q : ptr_q + STEP;
        end
    end

    assign ptr  = ptr_q;
    assign base = base_q;

    AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable && base_wr |=> $stable(base_q)); // R10
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !(base_wr && !rx_enable) |=> (ptr_q == base_q) || (ptr_q == $past(ptr_q) + STEP)); // R3
    AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !adv && !base_wr |=> $stable(ptr_q)); // R3

endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rx_ring_pkg::*;
#(
    parameter int SZ_W      = 8,
    parameter int UNIT_LOG2 = 6,
    parameter int SIZE_RST  = 2,
    parameter int OFF_W     = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              cfg_base_wr,
    input  logic [31:0]       cfg_base_wdata,
    output logic [31:0]       cfg_base_rdata,
    input  logic              cfg_size_wr,
    input  logic [SZ_W-1:0]   cfg_size_wdata,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    output logic [3:0]        mem_req_be,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    output logic              bna_irq,
    output logic              bna_flag,
    output logic [CNT_W-1:0]  res_err_cnt
    ,
    output logic              ovr_irq
);

    localparam int BYTES_W = SZ_W + UNIT_LOG2;
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    rx_state_e state_q, state_d;

    logic [SZ_W-1:0]       size_q;
    logic [SZ_W-1:0]       size_eff;
    logic [BYTES_W-1:0]    buf_bytes;
    logic [BYTES_W-1:0]    rem_q;
    logic [ADDR_W-1:0]     buf_q, wa_q;
    logic                  wrap_q, first_q, last_q, abort_q, in_frame_q;
    logic [STAT_LEN_W-1:0] len_q;
    logic [BYTES_W-1:0]    off_b;
    logic [ADDR_W-1:0]     off_a;
    logic [ADDR_W-1:0]     ptr, base;

    logic capture, consume, flush, adv, fetch_ok, fetch_bna, ovr;
    logic hold_valid, hold_eof, hold_err;
    logic [7:0] hold_data;

    // Input framing: track frame boundaries on the wire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            in_frame_q <= 1'b0;
        else if (in_valid) begin
            if (in_eof)
                in_frame_q <= 1'b0;
            else if (in_sof && rx_enable && !in_frame_q)
                in_frame_q <= 1'b1;
        end
    end

    assign capture = in_valid && (state_q != S_DROP) && (in_frame_q || (in_sof && rx_enable));

    rx_byte_hold #(.DW(8)) hold_i (
        .clk(clk), .rst_n(rst_n), .capture(capture), .in_data(in_data),
        .in_eof(in_eof), .in_err(in_err), .consume(consume), .flush(flush),
        .hold_valid(hold_valid), .hold_data(hold_data), .hold_eof(hold_eof),
        .hold_err(hold_err), .ovr(ovr)
    );

    rx_ring_ptr ptr_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_wr(cfg_base_wr),
        .base_wdata(cfg_base_wdata), .adv(adv), .wrap(wrap_q), .ptr(ptr), .base(base)
    );

    assign cfg_base_rdata = ptr;

    // Buffer size register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            size_q <= SZ_W'(SIZE_RST);
        else if (cfg_size_wr)
            size_q <= cfg_size_wdata;
    end

    assign size_eff  = (size_q == '0) ? SZ_W'(1) : size_q;
    assign buf_bytes = BYTES_W'(size_eff) << UNIT_LOG2;
    assign off_b     = first_q ? BYTES_W'(cfg_offset) : '0;
    assign off_a     = first_q ? ADDR_W'(cfg_offset) : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d       = state_q;
        consume       = 1'b0;
        flush         = 1'b0;
        adv           = 1'b0;
        fetch_ok      = 1'b0;
        fetch_bna     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = ptr;
        mem_req_wdata = '0;
        mem_req_be    = 4'hF;
        unique case (state_q)
            S_IDLE: begin
                if (hold_valid)
                    state_d = S_FETCH;
            end
            S_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready)
                    state_d = S_FWAIT;
            end
            S_FWAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_rdata[0]) begin
                        fetch_bna = 1'b1;
                        flush     = 1'b1;
                        state_d   = S_DROP;
                    end else begin
                        fetch_ok = 1'b1;
                        state_d  = S_DATA;
                    end
                end
            end
            S_DATA: begin
                if (abort_q || (hold_valid && hold_err)) begin
                    flush   = 1'b1;
                    state_d = S_DROP;
                end else if (hold_valid) begin
                    state_d = (rem_q == '0) ? S_STAT : S_WR;
                end
            end
            S_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = wa_q & WORD_MASK;
                mem_req_wdata = {4{hold_data}};
                mem_req_be    = 4'b0001 << wa_q[1:0];
                if (mem_req_ready) begin
                    consume = 1'b1;
                    state_d = hold_eof ? S_STAT : S_DATA;
                end
            end
            S_STAT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = ptr + ADDR_W'(4);
                mem_req_wdata = mk_status(last_q, first_q, last_q ? len_q : '0);
                if (mem_req_ready)
                    state_d = S_MARK;
            end
            S_MARK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = buf_q | {30'd0, wrap_q, 1'b1};
                if (mem_req_ready) begin
                    adv     = 1'b1;
                    state_d = last_q ? S_IDLE : S_FETCH;
                end
            end
            S_DROP: begin
                if (!in_frame_q)
                    state_d = S_IDLE;
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q       <= '0;
            wa_q        <= '0;
            wrap_q      <= 1'b0;
            rem_q       <= '0;
            len_q       <= '0;
            first_q     <= 1'b0;
            last_q      <= 1'b0;
            abort_q     <= 1'b0;
            bna_irq     <= 1'b0;
            bna_flag    <= 1'b0;
            res_err_cnt <= '0;
            ovr_irq     <= 1'b0;
        end else begin
            bna_irq <= fetch_bna;
            ovr_irq <= ovr;
            if (flush)
                abort_q <= 1'b0;
            else if (ovr)
                abort_q <= 1'b1;
            if (state_q == S_IDLE && hold_valid) begin
                first_q <= 1'b1;
                last_q  <= 1'b0;
                len_q   <= '0;
            end
            if (fetch_ok) begin
                buf_q    <= mem_rsp_rdata & WORD_MASK;
                wrap_q   <= mem_rsp_rdata[1];
                wa_q     <= (mem_rsp_rdata & WORD_MASK) + off_a;
                rem_q    <= buf_bytes - off_b;
                bna_flag <= 1'b0;
            end
            if (fetch_bna) begin
                bna_flag    <= 1'b1;
                res_err_cnt <= res_err_cnt + 1'b1;
            end
            if (consume) begin
                wa_q   <= wa_q + 1'b1;
                rem_q  <= rem_q - 1'b1;
                len_q  <= len_q + 1'b1;
                last_q <= hold_eof;
            end
            if (adv)
                first_q <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R12
    AST_MARK_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_MARK) |-> $past(state_q) == S_STAT); // R4
    AST_BNA_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bna_irq |=> $stable(cfg_base_rdata)); // R6
    AST_WR_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WR |-> rem_q != '0); // R2

endmodule

// File: tb/rx_ring_mgr_tb.sv
`timescale 1ns/1ps
module rx_ring_mgr_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, rx_enable, cfg_base_wr, cfg_size_wr;
    logic [31:0] cfg_base_wdata, cfg_base_rdata;
    logic [7:0]  cfg_size_wdata;
    logic [1:0]  cfg_offset;
    logic        in_valid, in_sof, in_eof, in_err;
    logic [7:0]  in_data;
    logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
    logic [3:0]  mem_req_be;
    logic        bna_irq, bna_flag, ovr_irq;
    logic [15:0] res_err_cnt;

    rx_ring_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_base_wr(cfg_base_wr),
        .cfg_base_wdata(cfg_base_wdata), .cfg_base_rdata(cfg_base_rdata),
        .cfg_size_wr(cfg_size_wr), .cfg_size_wdata(cfg_size_wdata), .cfg_offset(cfg_offset),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .bna_irq(bna_irq), .bna_flag(bna_flag), .res_err_cnt(res_err_cnt), .ovr_irq(ovr_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int bna_pulses = 0;
    int ovr_pulses = 0;

    // Behavioural memory with a software write port
    logic [31:0] mem [0:1023];
    logic        stall = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_addr, sw_data;

    assign mem_req_ready = !stall;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (sw_wr)
            mem[sw_addr[11:2]] <= sw_data;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < 4; b++)
                    if (mem_req_be[b])
                        mem[mem_req_addr[11:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[11:2]];
            end
        end
    end

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t         exp_q[$];
    logic [31:0] eb_addr[$];
    logic [7:0]  eb_val[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: descriptor write-backs compared against the scoreboard
    always @(negedge clk) begin
        if (!done && rst_n) begin
            if (bna_irq) bna_pulses++;
            if (ovr_irq) ovr_pulses++;
            if (mem_req_valid && mem_req_ready && mem_req_write && mem_req_addr < 32'h400) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R4/R5 unexpected write actual=%h:%h expected=none",
                             mem_req_addr, mem_req_wdata);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    if (mem_req_addr !== e.a || mem_req_wdata !== e.d) begin
                        fails++;
                        $display("FAIL R4/R5 write actual=%h:%h expected=%h:%h",
                                 mem_req_addr, mem_req_wdata, e.a, e.d);
                    end
                end
            end
        end
    end

    // Ring model: 4 descriptors at 0x40, buffers at 0x400 + 0x100*i
    int m_idx  = 0;
    int m_size = 128;
    int m_off  = 0;

    function automatic logic [31:0] d_addr(input int i); return 32'h40 + 32'(8*i); endfunction
    function automatic logic [31:0] b_addr(input int i); return 32'h400 + 32'(256*i); endfunction
    function automatic logic [31:0] w0(input int i); return b_addr(i) | ((i == 3) ? 32'h2 : 32'h0); endfunction

    task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); sw_wr = 1'b1; sw_addr = a; sw_data = d;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic release_all();
        for (int i = 0; i < 4; i++) sw_write(d_addr(i), w0(i));
    endtask

    task automatic drive_frame(input int len, input int err_at, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(seed + k);
            in_sof = (k == 0); in_eof = (k == len - 1); in_err = (k == err_at);
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
            repeat (14) @(negedge clk);
        end
    endtask

    task automatic push_close(input bit fin, input bit first, input int len);
        logic [31:0] st;
        st = (first ? 32'h4000 : 32'h0) | (fin ? (32'h8000 | 32'(len)) : 32'h0);
        exp_q.push_back('{d_addr(m_idx) + 4, st});
        exp_q.push_back('{d_addr(m_idx), w0(m_idx) | 32'h1});
        m_idx = (m_idx + 1) % 4;
    endtask

    task automatic send_frame(input int len, input int err_at, input int seed, input string req);
        bit first;
        int rem;
        logic [31:0] wa;
        int mism;
        first = 1; rem = m_size - m_off; wa = b_addr(m_idx) + 32'(m_off);
        eb_addr.delete(); eb_val.delete();
        for (int k = 0; k < len; k++) begin
            if (k == err_at) break;
            if (rem == 0) begin
                push_close(0, first, 0);
                first = 0; rem = m_size; wa = b_addr(m_idx);
            end
            eb_addr.push_back(wa); eb_val.push_back(8'(seed + k));
            wa++; rem--;
            if (k == len - 1) push_close(1, first, len);
        end
        drive_frame(len, err_at, seed);
        repeat (30) @(negedge clk);
        chk({req, " write-backs drained"}, 32'(exp_q.size()), 32'd0);
        mism = 0;
        for (int i = 0; i < eb_addr.size(); i++)
            if (mem[eb_addr[i][11:2]][8*eb_addr[i][1:0] +: 8] !== eb_val[i]) mism++;
        chk({req, " R1 data bytes"}, 32'(mism), 32'd0);
        chk({req, " R3 pointer"}, cfg_base_rdata, d_addr(m_idx));
    endtask

    initial begin
        rst_n = 1'b0; rx_enable = 1'b0; cfg_base_wr = 1'b0; cfg_base_wdata = '0;
        cfg_size_wr = 1'b0; cfg_size_wdata = '0; cfg_offset = '0;
        in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset pointer", cfg_base_rdata, 32'h0);
        chk("R6 reset counter", 32'(res_err_cnt), 32'h0);
        chk("R6 reset flag", 32'(bna_flag), 32'h0);
        chk("R12 idle request", 32'(mem_req_valid), 32'h0);

        // R10: base write while disabled takes effect
        cfg_base_wr = 1'b1; cfg_base_wdata = 32'h45;
        @(negedge clk); cfg_base_wr = 1'b0;
        chk("R10 aligned base", cfg_base_rdata, 32'h40);
        release_all();
        rx_enable = 1'b1;

        // R2 default 128-byte buffers, frame over two buffers
        send_frame(200, -1, 8'h10, "R2 R5 two-buffer");

        // R9 offset 2 with 64-byte buffers, R3 wrap back to base
        cfg_size_wr = 1'b1; cfg_size_wdata = 8'd1;
        @(negedge clk); cfg_size_wr = 1'b0;
        m_size = 64; m_off = 2; cfg_offset = 2'd2;
        send_frame(70, -1, 8'h33, "R9 R3 offset+wrap");
        release_all();

        // R2 zero size acts as 64, exact fit
        cfg_size_wr = 1'b1; cfg_size_wdata = 8'd0;
        @(negedge clk); cfg_size_wr = 1'b0;
        m_off = 0; cfg_offset = 2'd0;
        send_frame(64, -1, 8'h50, "R2 exact fit");

        // R7 error mid second buffer, then reuse of recovered buffer
        send_frame(100, 80, 8'h70, "R7 error frame");
        send_frame(10, -1, 8'h90, "R7 reuse");

        // R6 buffer not available
        sw_write(d_addr(3), w0(3) | 32'h1);
        drive_frame(20, -1, 8'hA0);
        repeat (30) @(negedge clk);
        chk("R6 counter", 32'(res_err_cnt), 32'd1);
        chk("R6 flag set", 32'(bna_flag), 32'd1);
        chk("R6 pulse", 32'(bna_pulses), 32'd1);
        chk("R6 pointer held", cfg_base_rdata, d_addr(3));
        sw_write(d_addr(3), w0(3));
        send_frame(5, -1, 8'hB0, "R6 refetch");
        chk("R6 flag cleared", 32'(bna_flag), 32'd0);

        // R8 overrun while the descriptor read is stalled
        release_all();
        stall = 1'b1;
        drive_frame(4, -1, 8'hC0);
        stall = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 overrun pulses", 32'(ovr_pulses), 32'd3);
        chk("R8 pointer held", cfg_base_rdata, d_addr(0));
        send_frame(3, -1, 8'hD0, "R8 reuse");

        // R11 bytes without start and frames while disabled are ignored
        @(negedge clk); in_valid = 1'b1; in_data = 8'hEE;
        @(negedge clk); in_valid = 1'b0;
        rx_enable = 1'b0;
        drive_frame(5, -1, 8'hE0);
        repeat (20) @(negedge clk);
        chk("R11 pointer unchanged", cfg_base_rdata, d_addr(1));
        chk("R11 no write-backs", 32'(exp_q.size()), 32'd0);

        // R10 base write ignored while enabled
        rx_enable = 1'b1;
        cfg_base_wr = 1'b1; cfg_base_wdata = 32'h80;
        @(negedge clk); cfg_base_wr = 1'b0;
        @(negedge clk);
        chk("R10 write ignored", cfg_base_rdata, d_addr(1));
        rx_enable = 1'b0;
        cfg_base_wr = 1'b1; cfg_base_wdata = 32'h40;
        @(negedge clk); cfg_base_wr = 1'b0;
        @(negedge clk);
        chk("R10 write accepted", cfg_base_rdata, 32'h40);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule